// File: doc/BRIEF.md
# MDIO Management Frame Slave

This block is the device-side agent of a two-wire serial management bus. It watches the management clock (MDC) and the shared bidirectional data line (MDIO), and decodes read and write frames aimed at its own configured device address. A write delivers a 5-bit register number and a 16-bit value to a register-file port as a single strobe. A read fetches a 16-bit value from the same port and shifts it back onto the line after the turnaround. The line is driven through a separate output enable, and the register contents themselves live outside the block.

MDC is not used as a clock. The block runs entirely on a fast system clock, and MDC and MDIO pass through two-flop synchronizers before a rising-edge detector. A slow bus master, even one that toggles MDC from a microcontroller port, is handled the same way as a fast one, as long as MDC is no faster than the 400 ns minimum period.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive one bits on MDIO. With fewer ones before the start field, the frame causes no strobe and no drive. Extra ones beyond 32 are allowed.
- R2: The start field must be a 0 followed by a 1. Any other pair abandons the frame and returns the block to preamble hunting.
- R3: The opcode bits, first then second, must be 1,0 (read) or 0,1 (write). The pairs 0,0 and 1,1 abandon the frame with no strobe and with MDIO left released.
- R4: The 5-bit device address is received MSB first and compared with `phy_addr`. On a mismatch there is no strobe and MDIO is never driven.
- R5: In a write, the register number is received MSB first after the device address, and the turnaround must read 1 then 0; otherwise the frame is discarded. The 16 data bits follow MSB first. Exactly one `reg_wr_en` pulse, one clock long, follows the last data bit, with `reg_addr` and `reg_wr_data` valid during it.
- R6: In a matching read, one `reg_rd_en` pulse, one clock long, is issued with `reg_addr` after the last register bit, while MDIO is still released. `reg_rd_data` is taken on the following clock.
- R7: In a read turnaround, MDIO is released during the first bit and driven to 0 during the second. Each change is made after an MDC rising edge.
- R8: The read data is driven MSB first, one bit per MDC cycle, each bit changing after a rising edge. MDIO is released after the rising edge that samples the last bit.
- R9: While `rst` is high, and on the clock after it, `mdio_oe`, `reg_wr_en` and `reg_rd_en` are low.
- R10: Frames decode correctly at the minimum 400 ns MDC period and at any slower period.
- R11: `reg_wr_en` and `reg_rd_en` are never high together, and neither stays high for two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than MDC |
| rst | input | 1 | Synchronous active-high reset |
| phy_addr | input | 5 | Device address this agent answers to |
| mdc | input | 1 | Management clock from the bus master (asynchronous) |
| mdio_in | input | 1 | Value currently on the MDIO line |
| mdio_out | output | 1 | Value driven onto MDIO when enabled |
| mdio_oe | output | 1 | Tri-state enable for MDIO |
| reg_addr | output | 5 | Register number for the register-file port |
| reg_wr_en | output | 1 | One-clock write strobe |
| reg_wr_data | output | 16 | Write data, valid with `reg_wr_en` |
| reg_rd_en | output | 1 | One-clock read request |
| reg_rd_data | input | 16 | Read data, returned one clock after `reg_rd_en` |

## Verification
On every cycle the assertions check the strobe rules: single-clock pulses that never overlap, a stable register number during a write, and no read request while the line is driven. They also check that the driver always starts from a 0 turnaround bit and that the outputs are quiet after reset. Only the bench's frames can show the decoding: whether short preambles, bad start or opcode pairs, foreign addresses and bad write turnarounds are really dropped. The bench also shows that read data comes back in the right order and in the right MDC cycle, and that the decoding works at both the fastest and a much slower MDC rate.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

  typedef enum logic [2:0] {
    ST_PRE,
    ST_SOF,
    ST_OP,
    ST_ADR,
    ST_TA,
    ST_DAT
  } mdio_state_t;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  // one-clock commands from the frame decoder to the line driver
  typedef struct packed {
    logic ta_zero;  // start driving the second turnaround bit
    logic shift;    // put the next data bit on the line
    logic release_; // stop driving
  } mdio_tx_cmd_t;

endpackage

// File: rtl/mdio_slv_sync.sv
module mdio_slv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mdc_raw,
  input  logic mdio_raw,
  output logic bit_rise,
  output logic bit_val
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] mdc_q;
  logic [LAST:0] mdio_q;
  logic          mdc_prev;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          mdc_q  <= '0;
          mdio_q <= '1;
        end else begin
          mdc_q  <= {mdc_q[LAST-1:0], mdc_raw};
          mdio_q <= {mdio_q[LAST-1:0], mdio_raw};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          mdc_q  <= '0;
          mdio_q <= '1;
        end else begin
          mdc_q  <= mdc_raw;
          mdio_q <= mdio_raw;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) mdc_prev <= 1'b0;
    else     mdc_prev <= mdc_q[LAST];
  end

  // MDIO travels through the same number of stages, so it lines up with the edge
  assign bit_rise = mdc_q[LAST] & ~mdc_prev;
  assign bit_val  = mdio_q[LAST];

endmodule

// File: rtl/mdio_slv_rx.sv
module mdio_slv_rx
  import mdio_slv_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int AW      = 5,
  parameter int DW      = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_rise,
  input  logic          bit_val,
  input  logic [AW-1:0] phy_addr,
  output logic [AW-1:0] reg_addr,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          rd_en,
  output mdio_tx_cmd_t  tx_cmd
);

  localparam int PRE_W = $clog2(PRE_LEN + 1);
  localparam int DAT_W = $clog2(DW + 1);
  localparam int CNT_W = (PRE_W > DAT_W) ? PRE_W : DAT_W;
  localparam int ADR_BITS = 2 * AW;
  localparam logic [CNT_W-1:0] PRE_FULL = CNT_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] ADR_LAST = CNT_W'(ADR_BITS - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DW - 1);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  mdio_state_t         state;
  logic [CNT_W-1:0]    cnt;
  logic                op_first;
  logic                is_rd;
  logic                hit;
  logic [ADR_BITS-1:0] adr_sh;
  logic [DW-1:0]       dat_sh;

  logic [ADR_BITS-1:0] adr_nxt;
  logic [DW-1:0]       dat_nxt;
  logic                adr_hit;

  assign adr_nxt = {adr_sh[ADR_BITS-2:0], bit_val};
  assign dat_nxt = {dat_sh[DW-2:0], bit_val};
  assign adr_hit = (adr_nxt[ADR_BITS-1:AW] == phy_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_PRE;
      cnt      <= '0;
      op_first <= 1'b0;
      is_rd    <= 1'b0;
      hit      <= 1'b0;
      adr_sh   <= '0;
      dat_sh   <= '0;
      reg_addr <= '0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      rd_en    <= 1'b0;
      tx_cmd   <= '0;
    end else begin
      wr_en  <= 1'b0;
      rd_en  <= 1'b0;
      tx_cmd <= '0;
      if (bit_rise) begin
        case (state)
          ST_PRE: begin
            if (bit_val) begin
              if (cnt != PRE_FULL) cnt <= cnt + ONE;
            end else begin
              // a zero after a full run of ones is the first start bit
              if (cnt == PRE_FULL) state <= ST_SOF;
              cnt <= '0;
            end
          end
          ST_SOF: begin
            state <= bit_val ? ST_OP : ST_PRE;
            cnt   <= '0;
          end
          ST_OP: begin
            if (cnt == '0) begin
              op_first <= bit_val;
              cnt      <= ONE;
            end else begin
              cnt <= '0;
              if ({op_first, bit_val} == OP_READ) begin
                is_rd <= 1'b1;
                state <= ST_ADR;
              end else if ({op_first, bit_val} == OP_WRITE) begin
                is_rd <= 1'b0;
                state <= ST_ADR;
              end else begin
                state <= ST_PRE;
              end
            end
          end
          ST_ADR: begin
            adr_sh <= adr_nxt;
            if (cnt == ADR_LAST) begin
              cnt      <= '0;
              state    <= ST_TA;
              reg_addr <= adr_nxt[AW-1:0];
              hit      <= adr_hit;
              if (adr_hit && is_rd) rd_en <= 1'b1;
            end else begin
              cnt <= cnt + ONE;
            end
          end
          ST_TA: begin
            if (cnt == '0) begin
              if (!is_rd && !bit_val) begin
                state <= ST_PRE;
                cnt   <= '0;
              end else begin
                cnt <= ONE;
                if (is_rd && hit) tx_cmd.ta_zero <= 1'b1;
              end
            end else begin
              cnt <= '0;
              if (!is_rd && bit_val) begin
                state <= ST_PRE;
              end else begin
                state <= ST_DAT;
                if (is_rd && hit) tx_cmd.shift <= 1'b1;
              end
            end
          end
          ST_DAT: begin
            dat_sh <= dat_nxt;
            if (cnt == DAT_LAST) begin
              cnt   <= '0;
              state <= ST_PRE;
              if (hit) begin
                if (is_rd) begin
                  tx_cmd.release_ <= 1'b1;
                end else begin
                  wr_en   <= 1'b1;
                  wr_data <= dat_nxt;
                end
              end
            end else begin
              cnt <= cnt + ONE;
              if (is_rd && hit) tx_cmd.shift <= 1'b1;
            end
          end
          default: begin
            state <= ST_PRE;
            cnt   <= '0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/mdio_slv_tx.sv
module mdio_slv_tx
  import mdio_slv_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  mdio_tx_cmd_t  tx_cmd,
  input  logic          rd_en,
  input  logic [DW-1:0] rd_data,
  output logic          mdio_out,
  output logic          mdio_oe
);

  logic          rd_q;
  logic [DW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q     <= 1'b0;
      sh       <= '0;
      mdio_out <= 1'b0;
      mdio_oe  <= 1'b0;
    end else begin
      rd_q <= rd_en;
      // the register file answers one clock after the request
      if (rd_q) sh <= rd_data;
      if (tx_cmd.ta_zero) begin
        mdio_oe  <= 1'b1;
        mdio_out <= 1'b0;
      end
      if (tx_cmd.shift) begin
        mdio_out <= sh[DW-1];
        sh       <= {sh[DW-2:0], 1'b0};
      end
      if (tx_cmd.release_) begin
        mdio_oe  <= 1'b0;
        mdio_out <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_slv_pkg::*;
#(
  parameter int PRE_LEN     = 32,
  parameter int AW          = 5,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] phy_addr,
  input  logic          mdc,
  input  logic          mdio_in,
  output logic          mdio_out,
  output logic          mdio_oe,
  output logic [AW-1:0] reg_addr,
  output logic          reg_wr_en,
  output logic [DW-1:0] reg_wr_data,
  output logic          reg_rd_en,
  input  logic [DW-1:0] reg_rd_data
);

  logic         bit_rise;
  logic         bit_val;
  mdio_tx_cmd_t tx_cmd;

  mdio_slv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .mdc_raw  (mdc),
    .mdio_raw (mdio_in),
    .bit_rise (bit_rise),
    .bit_val  (bit_val)
  );

  mdio_slv_rx #(.PRE_LEN(PRE_LEN), .AW(AW), .DW(DW)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .bit_rise (bit_rise),
    .bit_val  (bit_val),
    .phy_addr (phy_addr),
    .reg_addr (reg_addr),
    .wr_en    (reg_wr_en),
    .wr_data  (reg_wr_data),
    .rd_en    (reg_rd_en),
    .tx_cmd   (tx_cmd)
  );

  mdio_slv_tx #(.DW(DW)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .tx_cmd   (tx_cmd),
    .rd_en    (reg_rd_en),
    .rd_data  (reg_rd_data),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe)
  );

endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mdio_out,
  input logic          mdio_oe,
  input logic [AW-1:0] reg_addr,
  input logic          reg_wr_en,
  input logic [DW-1:0] reg_wr_data,
  input logic          reg_rd_en
);

  // R11: strobes never overlap
  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_en && reg_rd_en));

  // R11: write strobe lasts one clock
  p_wr_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> !reg_wr_en);

  // R11: read request lasts one clock
  p_rd_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en |=> !reg_rd_en);

  // R5: register number settled well before the write strobe
  p_wr_addr_stable_r5: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |-> $stable(reg_addr));

  // R6: the fetch happens while the line is still released
  p_rd_released_r6: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en |-> !mdio_oe);

  // R7: driving always begins with the zero turnaround bit
  p_ta_zero_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> !mdio_out);

  // R9: quiet outputs after reset
  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!mdio_oe && !reg_wr_en && !reg_rd_en));

  logic unused_data;
  assign unused_data = ^reg_wr_data;

endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mdio_out    (mdio_out),
  .mdio_oe     (mdio_oe),
  .reg_addr    (reg_addr),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_data (reg_wr_data),
  .reg_rd_en   (reg_rd_en)
);

// File: tb/mdio_mgmt_slave_bench.sv
module mdio_mgmt_slave_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  phy_addr = 5'h0B;
  logic        mdc = 1'b0;
  logic        m_bit = 1'b1;
  logic        m_en = 1'b0;
  logic        line;
  logic        mdio_out, mdio_oe;
  logic [4:0]  reg_addr;
  logic        reg_wr_en, reg_rd_en;
  logic [15:0] reg_wr_data;
  logic [15:0] reg_rd_data = '0;

  int total = 0;
  int bad = 0;
  int half = 10;  // system clocks per MDC phase: 20 clocks = 400 ns period

  int n_wr = 0, n_rd = 0, n_oe_rise = 0, n_contend = 0;
  logic [4:0]  last_wa = '0;
  logic [15:0] last_wd = '0;
  logic        prev_oe = 1'b0;
  logic [15:0] rf [32];
  logic [15:0] shadow [32];

  always #10 clk = ~clk;  // 50 MHz

  // pull-up on the shared line
  assign line = mdio_oe ? mdio_out : (m_en ? m_bit : 1'b1);

  mdio_mgmt_slave u_mdio_mgmt_slave (
    .clk (clk), .rst (rst), .phy_addr (phy_addr), .mdc (mdc),
    .mdio_in (line), .mdio_out (mdio_out), .mdio_oe (mdio_oe),
    .reg_addr (reg_addr), .reg_wr_en (reg_wr_en), .reg_wr_data (reg_wr_data),
    .reg_rd_en (reg_rd_en), .reg_rd_data (reg_rd_data)
  );

  // register file model and event counters
  always @(posedge clk) begin
    if (reg_wr_en) begin
      n_wr++;
      last_wa <= reg_addr;
      last_wd <= reg_wr_data;
      rf[reg_addr] <= reg_wr_data;
    end
    if (reg_rd_en) begin
      n_rd++;
      reg_rd_data <= rf[reg_addr];
    end
    if (mdio_oe && !prev_oe) n_oe_rise++;
    prev_oe <= mdio_oe;
  end

  always @(negedge clk) if (mdio_oe && m_en) n_contend++;

  function automatic logic [4:0] other_addr(input logic [4:0] a, input int unsigned r);
    return a ^ 5'((r % 31) + 1);
  endfunction

  function automatic logic [15:0] released_word();
    return 16'hFFFF;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic b, input logic en, output logic seen);
    mdc = 1'b0; m_bit = b; m_en = en;
    repeat (half) @(negedge clk);
    seen = line;
    mdc = 1'b1;
    repeat (half) @(negedge clk);
  endtask

  task automatic frame(input int npre, input logic [1:0] sof, input logic [1:0] op,
                       input logic [4:0] pa, input logic [4:0] ra, input logic [1:0] ta,
                       input logic [15:0] wd, input logic rd,
                       output logic [1:0] ta_seen, output logic [15:0] rd_seen);
    logic s;
    for (int i = 0; i < npre; i++) cyc(1'b1, 1'b1, s);
    cyc(sof[1], 1'b1, s); cyc(sof[0], 1'b1, s);
    cyc(op[1], 1'b1, s);  cyc(op[0], 1'b1, s);
    for (int i = 4; i >= 0; i--) cyc(pa[i], 1'b1, s);
    for (int i = 4; i >= 0; i--) cyc(ra[i], 1'b1, s);
    cyc(ta[1], !rd, s); ta_seen[1] = s;
    cyc(ta[0], !rd, s); ta_seen[0] = s;
    for (int i = 15; i >= 0; i--) begin
      cyc(wd[i], !rd, s); rd_seen[i] = s;
    end
    // master drives a 0 idle bit: catches a late release and clears any ones count
    cyc(1'b0, 1'b1, s);
    m_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
    logic [1:0] t; logic [15:0] d;
    frame(32, 2'b01, 2'b01, pa, ra, 2'b10, wd, 1'b0, t, d);
  endtask

  task automatic do_read(input logic [4:0] pa, input logic [4:0] ra,
                         output logic [1:0] t, output logic [15:0] d);
    frame(32, 2'b01, 2'b10, pa, ra, 2'b11, 16'h0, 1'b1, t, d);
  endtask

  initial begin : main
    logic [1:0] t; logic [15:0] d;
    int w0, r0, o0;
    int unsigned rnd;
    for (int i = 0; i < 32; i++) begin rf[i] = '0; shadow[i] = '0; end
    rnd = $urandom(32'd2024);
    repeat (5) @(negedge clk);
    // R9: outputs quiet in reset
    chk(!mdio_oe && !reg_wr_en && !reg_rd_en, "R9 reset", {29'd0, mdio_oe, reg_wr_en, reg_rd_en}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R5: matching write
    w0 = n_wr;
    do_write(phy_addr, 5'd3, 16'hA5C3); shadow[3] = 16'hA5C3;
    chk(n_wr == w0 + 1, "R5 one write strobe", n_wr - w0, 1);
    chk(last_wa == 5'd3 && last_wd == 16'hA5C3, "R5 write addr/data", {11'd0, last_wa, last_wd}, {11'd0, 5'd3, 16'hA5C3});

    // R6 R7 R8: matching read
    r0 = n_rd;
    do_read(phy_addr, 5'd3, t, d);
    chk(n_rd == r0 + 1, "R6 one read request", n_rd - r0, 1);
    chk(t == 2'b10, "R7 turnaround released then 0", t, 2'b10);
    chk(d == shadow[3], "R8 read data", d, shadow[3]);
    chk(!mdio_oe && n_contend == 0, "R8 released after last bit", {mdio_oe, 15'd0, 16'(n_contend)}, 0);

    // R4: foreign address write and read
    w0 = n_wr; o0 = n_oe_rise;
    do_write(other_addr(phy_addr, 3), 5'd3, 16'h1111);
    chk(n_wr == w0, "R4 foreign write ignored", n_wr - w0, 0);
    do_read(other_addr(phy_addr, 7), 5'd3, t, d);
    chk(n_oe_rise == o0 && d == released_word(), "R4 foreign read undriven", d, released_word());
    do_read(phy_addr, 5'd3, t, d);
    chk(d == shadow[3], "R4 register kept", d, shadow[3]);

    // R1: short and long preambles
    w0 = n_wr;
    frame(31, 2'b01, 2'b01, phy_addr, 5'd7, 2'b10, 16'hDEAD, 1'b0, t, d);
    chk(n_wr == w0, "R1 short preamble ignored", n_wr - w0, 0);
    frame(45, 2'b01, 2'b01, phy_addr, 5'd7, 2'b10, 16'h1234, 1'b0, t, d); shadow[7] = 16'h1234;
    chk(n_wr == w0 + 1, "R1 long preamble accepted", n_wr - w0, 1);

    // R2: bad start field, then a good frame
    w0 = n_wr;
    frame(32, 2'b00, 2'b01, phy_addr, 5'd7, 2'b10, 16'hBEEF, 1'b0, t, d);
    chk(n_wr == w0, "R2 bad start ignored", n_wr - w0, 0);
    do_read(phy_addr, 5'd7, t, d);
    chk(d == shadow[7], "R2 recovery read", d, shadow[7]);

    // R3: illegal opcodes
    w0 = n_wr; r0 = n_rd; o0 = n_oe_rise;
    frame(32, 2'b01, 2'b00, phy_addr, 5'd7, 2'b10, 16'h0F0F, 1'b0, t, d);
    frame(32, 2'b01, 2'b11, phy_addr, 5'd7, 2'b10, 16'h0F0F, 1'b1, t, d);
    chk(n_wr == w0 && n_rd == r0 && n_oe_rise == o0, "R3 bad opcode ignored",
        {16'(n_wr - w0), 16'(n_oe_rise - o0)}, 0);

    // R5: bad write turnaround
    w0 = n_wr;
    frame(32, 2'b01, 2'b01, phy_addr, 5'd9, 2'b00, 16'h7777, 1'b0, t, d);
    frame(32, 2'b01, 2'b01, phy_addr, 5'd9, 2'b11, 16'h7777, 1'b0, t, d);
    chk(n_wr == w0, "R5 bad turnaround discarded", n_wr - w0, 0);

    // R4: a different configured address
    phy_addr = 5'h1F;
    do_write(5'h1F, 5'd31, 16'h8001); shadow[31] = 16'h8001;
    do_read(5'h1F, 5'd31, t, d);
    chk(d == 16'h8001, "R4 new device address", d, 16'h8001);

    // R10: much slower MDC
    half = 40;
    do_write(phy_addr, 5'd0, 16'h5AA5); shadow[0] = 16'h5AA5;
    do_read(phy_addr, 5'd0, t, d);
    chk(d == 16'h5AA5 && t == 2'b10, "R10 slow MDC", d, 16'h5AA5);
    half = 10;

    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [4:0] ra; logic [15:0] wd; int kind;
      ra = 5'($urandom); wd = 16'($urandom); kind = int'($urandom % 4);
      w0 = n_wr; o0 = n_oe_rise;
      case (kind)
        0: begin
          do_write(phy_addr, ra, wd); shadow[ra] = wd;
          chk(n_wr == w0 + 1 && last_wd == wd, "R5 random write", last_wd, wd);
        end
        1: begin
          do_write(other_addr(phy_addr, $urandom), ra, wd);
          chk(n_wr == w0, "R4 random foreign write", n_wr - w0, 0);
        end
        2: begin
          do_read(phy_addr, ra, t, d);
          chk(d == shadow[ra] && t == 2'b10, "R8 random read", d, shadow[ra]);
        end
        default: begin
          do_read(other_addr(phy_addr, $urandom), ra, t, d);
          chk(n_oe_rise == o0 && d == released_word(), "R4 random foreign read", d, released_word());
        end
      endcase
    end
    chk(n_contend == 0, "R8 no bus contention", n_contend, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule